// File: doc/BRIEF.md
# UART Queue and Interrupt Controller

This block sits between a host and the serial shift logic of a UART. It holds two independent character queues: one carries bytes from the host to the transmit shifter, the other carries received bytes and their error flags from the receive shifter to the host. Each receive entry stores 12 bits: the character plus three line-error flags, and one flag marking that a character was lost just before it.

Seven interrupt sources are kept as sticky raw status bits:

- receive fill level
- transmit fill level
- receive timeout
- framing error
- parity error
- break
- overrun

Each bit stays set until the host clears it by writing a one. A mask picks which raw bits reach the single combined request.

The fill-level thresholds are chosen separately for each queue as a fraction of the depth. A timeout detector counts oversampling ticks and flags a receive queue that is holding data but has gone quiet. A busy flag tells the host when transmission has fully drained.

Top module: `uart_queue_irq`

## Requirements
- R1: Each queue holds up to DEPTH (16) entries and returns them in arrival order. The level output equals the number of entries held. Full is 1 at level 16 and empty is 1 at level 0.
- R2: A push into a full queue is dropped, even when a pop happens in the same cycle; that pop still removes one entry. A pop from an empty queue is ignored.
- R3: A dropped receive push sets raw bit 6 (overrun). The next accepted receive entry carries bit 11 = 1, and later entries carry 0.
- R4: Raw bit 0 (receive level) is set by an accepted receive push that raises the level to the threshold. The threshold select codes map to levels as follows: 0 → 2, 1 → 4, 2 → 8, 3 → 12, 4 → 14, and 5 to 7 → 8.
- R5: Raw bit 1 (transmit level) is set by a transmit pop that lowers the level to the transmit threshold. The threshold uses the same code mapping as R4.
- R6: An accepted receive push with status bits [0] framing, [1] parity, [2] break sets raw bits 3, 4 and 5 respectively. The same bits appear in entry bits 8, 9 and 10, and entry bits 7:0 hold the character.
- R7: Raw bit 2 (timeout) is set on the 512th oversampling tick (32 bit times of 16 ticks) after the last receive push or pop. It is set only while the receive queue holds 1 to 15 entries, and it fires once per quiet interval.
- R8: Raw bits stay set until cleared by a one on the matching clear input. A set event in the same cycle as a clear wins.
- R9: The masked status equals raw AND mask, and the request output is the OR of the masked bits.
- R10: Busy rises on the edge that accepts a transmit push. It falls only on an edge where the transmit queue is empty and the shifter reports no character in flight.
- R11: After reset, both queues are empty, all raw status bits are 0, the request is 0 and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud16_tick | input | 1 | Oversampling tick, 16 per bit time |
| tx_wr_en | input | 1 | Host push into transmit queue |
| tx_wr_data | input | 8 | Character to transmit |
| tx_rd_en | input | 1 | Shifter pop from transmit queue |
| tx_rd_data | output | 8 | Oldest transmit character |
| tx_shift_active | input | 1 | Shifter still sending a character, stop bits included |
| rx_wr_en | input | 1 | Shifter push into receive queue |
| rx_wr_data | input | 8 | Received character |
| rx_wr_stat | input | 3 | [0] framing, [1] parity, [2] break |
| rx_rd_en | input | 1 | Host pop from receive queue |
| rx_rd_data | output | 12 | Oldest receive entry (layout in R3, R6) |
| tx_lvl_sel | input | 3 | Transmit threshold code |
| rx_lvl_sel | input | 3 | Receive threshold code |
| irq_mask | input | 7 | Per-source enable |
| irq_clr | input | 7 | Write-one-to-clear per source |
| tx_level | output | 5 | Transmit entries held |
| rx_level | output | 5 | Receive entries held |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| irq_raw | output | 7 | Sticky raw status |
| irq_masked | output | 7 | Raw AND mask |
| irq | output | 1 | Combined request |
| busy | output | 1 | Transmission not yet drained |

## Verification
A status set and a host clear of the same bit can land in the same cycle. The bench provokes this by driving the clear of bit 0 together with the receive push that lifts the level onto the threshold, and it expects the bit to read 1 afterwards. Push and pop can also meet on a full receive queue. There the bench expects the level to drop to 15 and the overrun bit to be set, because the push is lost even though an entry leaves the queue.

// File: rtl/uart_qi_pkg.sv
`timescale 1ns/1ps
package uart_qi_pkg;
  localparam int NSRC      = 7;
  localparam int SRC_RXLVL = 0;
  localparam int SRC_TXLVL = 1;
  localparam int SRC_RXTO  = 2;
  localparam int SRC_FRM   = 3;
  localparam int SRC_PAR   = 4;
  localparam int SRC_BRK   = 5;
  localparam int SRC_OVR   = 6;

  // fractional fill threshold for a select code; undefined codes act as half
  function automatic int unsigned frac_level(input logic [2:0] sel, input int unsigned depth);
    case (sel)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth / 2;
    endcase
  endfunction
endpackage

// File: rtl/uart_qi_fifo.sv
`timescale 1ns/1ps
module uart_qi_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign wr_acc  = wr_en && !full;
  assign rd_acc  = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_acc) wr_ptr <= wr_ptr + AW'(1);
      if (rd_acc) rd_ptr <= rd_ptr + AW'(1);
      case ({wr_acc, rd_acc})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_drops_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en && full && !rd_en |=> count == CW'(DEPTH));
endmodule

// File: rtl/uart_qi_rxto.sv
`timescale 1ns/1ps
module uart_qi_rxto #(
  parameter  int LIMIT = 512,
  localparam int TW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic q_empty,
  input  logic q_full,
  output logic fire
);
  logic [TW-1:0] cnt;

  // saturating counter: one event per quiet interval
  assign fire = tick && !restart && !q_empty && !q_full && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || q_empty) cnt <= '0;
    else if (tick && cnt != TW'(LIMIT)) cnt <= cnt + TW'(1);
  end

  p_count_sat_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(LIMIT));
endmodule

// File: rtl/uart_qi_irq.sv
`timescale 1ns/1ps
module uart_qi_irq #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked,
  output logic         req
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)         raw[i] <= 1'b0;
      else if (set[i]) raw[i] <= 1'b1;
      else if (clr[i]) raw[i] <= 1'b0;
    end

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      raw[i] && !clr[i] |=> raw[i]);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> raw[i]);
  end

  assign masked = raw & mask;
  assign req    = |masked;
endmodule

// File: rtl/uart_queue_irq.sv
`timescale 1ns/1ps
module uart_queue_irq
  import uart_qi_pkg::*;
#(
  parameter  int DEPTH   = 16,
  parameter  int DW      = 8,
  parameter  int TO_BITS = 32,
  parameter  int OVS     = 16,
  localparam int CW      = $clog2(DEPTH) + 1,
  localparam int EW      = DW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud16_tick,
  input  logic          tx_wr_en,
  input  logic [DW-1:0] tx_wr_data,
  input  logic          tx_rd_en,
  output logic [DW-1:0] tx_rd_data,
  input  logic          tx_shift_active,
  input  logic          rx_wr_en,
  input  logic [DW-1:0] rx_wr_data,
  input  logic [2:0]    rx_wr_stat,
  input  logic          rx_rd_en,
  output logic [EW-1:0] rx_rd_data,
  input  logic [2:0]    tx_lvl_sel,
  input  logic [2:0]    rx_lvl_sel,
  input  logic [6:0]    irq_mask,
  input  logic [6:0]    irq_clr,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          rx_empty,
  output logic [6:0]    irq_raw,
  output logic [6:0]    irq_masked,
  output logic          irq,
  output logic          busy
);
  localparam int TO_LIMIT = TO_BITS * OVS;

  logic tx_wr_acc, tx_rd_acc, rx_wr_acc, rx_rd_acc;
  logic ovr_pend, to_fire;
  logic [CW-1:0] rx_thr, tx_thr;
  logic [NSRC-1:0] src_set;
  logic [EW-1:0] rx_din;

  assign rx_thr = CW'(frac_level(rx_lvl_sel, DEPTH));
  assign tx_thr = CW'(frac_level(tx_lvl_sel, DEPTH));
  assign rx_din = {ovr_pend, rx_wr_stat, rx_wr_data};

  uart_qi_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .wr_en(tx_wr_en), .wr_data(tx_wr_data),
    .rd_en(tx_rd_en), .rd_data(tx_rd_data), .wr_acc(tx_wr_acc), .rd_acc(tx_rd_acc),
    .count(tx_level), .full(tx_full), .empty(tx_empty));

  uart_qi_fifo #(.W(EW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .wr_en(rx_wr_en), .wr_data(rx_din),
    .rd_en(rx_rd_en), .rd_data(rx_rd_data), .wr_acc(rx_wr_acc), .rd_acc(rx_rd_acc),
    .count(rx_level), .full(rx_full), .empty(rx_empty));

  uart_qi_rxto #(.LIMIT(TO_LIMIT)) u_rxto (
    .clk(clk), .rst(rst), .tick(baud16_tick), .restart(rx_wr_acc || rx_rd_acc),
    .q_empty(rx_empty), .q_full(rx_full), .fire(to_fire));

  // lost-character marker carried by the next accepted receive entry
  always_ff @(posedge clk) begin
    if (rst)                        ovr_pend <= 1'b0;
    else if (rx_wr_en && rx_full)   ovr_pend <= 1'b1;
    else if (rx_wr_acc)             ovr_pend <= 1'b0;
  end

  always_comb begin
    src_set            = '0;
    src_set[SRC_RXLVL] = rx_wr_acc && !rx_rd_acc && (rx_level == rx_thr - CW'(1));
    src_set[SRC_TXLVL] = tx_rd_acc && !tx_wr_acc && (tx_level == tx_thr + CW'(1));
    src_set[SRC_RXTO]  = to_fire;
    src_set[SRC_FRM]   = rx_wr_acc && rx_wr_stat[0];
    src_set[SRC_PAR]   = rx_wr_acc && rx_wr_stat[1];
    src_set[SRC_BRK]   = rx_wr_acc && rx_wr_stat[2];
    src_set[SRC_OVR]   = rx_wr_en && rx_full;
  end

  uart_qi_irq #(.N(NSRC)) u_irq (
    .clk(clk), .rst(rst), .set(src_set), .clr(irq_clr), .mask(irq_mask),
    .raw(irq_raw), .masked(irq_masked), .req(irq));

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= tx_wr_acc || !tx_empty || tx_shift_active;
  end

  p_busy_on_write_r10: assert property (@(posedge clk) disable iff (rst)
    tx_wr_en && !tx_full |=> busy);
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    tx_shift_active |=> busy);
  p_overrun_flag_r3: assert property (@(posedge clk) disable iff (rst)
    rx_wr_en && rx_full |=> irq_raw[SRC_OVR]);
  p_timeout_needs_data_r7: assert property (@(posedge clk) disable iff (rst)
    rx_empty |=> !$rose(irq_raw[SRC_RXTO]));
endmodule

// File: tb/uart_queue_irq_bench.sv
`timescale 1ns/1ps
module uart_queue_irq_bench;
  logic clk = 1'b0, rst = 1'b1, baud16_tick = 1'b0;
  logic tx_wr_en = 1'b0, tx_rd_en = 1'b0, tx_shift_active = 1'b0;
  logic rx_wr_en = 1'b0, rx_rd_en = 1'b0;
  logic [7:0] tx_wr_data = '0, rx_wr_data = '0, tx_rd_data;
  logic [2:0] rx_wr_stat = '0, tx_lvl_sel = '0, rx_lvl_sel = '0;
  logic [11:0] rx_rd_data;
  logic [6:0] irq_mask = '0, irq_clr = '0, irq_raw, irq_masked;
  logic [4:0] tx_level, rx_level;
  logic tx_full, tx_empty, rx_full, rx_empty, irq, busy;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  uart_queue_irq u_uart_queue_irq (
    .clk(clk), .rst(rst), .baud16_tick(baud16_tick),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data),
    .tx_shift_active(tx_shift_active), .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
    .rx_wr_stat(rx_wr_stat), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
    .tx_lvl_sel(tx_lvl_sel), .rx_lvl_sel(rx_lvl_sel), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty), .irq_raw(irq_raw), .irq_masked(irq_masked),
    .irq(irq), .busy(busy));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int thr(input int sel);
    case (sel)
      0: return 2;  1: return 4;  2: return 8;  3: return 12;  4: return 14;
      default: return 8;
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic rx_push(input logic [7:0] d, input logic [2:0] st);
    rx_wr_en = 1'b1; rx_wr_data = d; rx_wr_stat = st; step(1); rx_wr_en = 1'b0;
  endtask
  task automatic rx_pop();
    rx_rd_en = 1'b1; step(1); rx_rd_en = 1'b0;
  endtask
  task automatic tx_push(input logic [7:0] d);
    tx_wr_en = 1'b1; tx_wr_data = d; step(1); tx_wr_en = 1'b0;
  endtask
  task automatic tx_pop();
    tx_rd_en = 1'b1; step(1); tx_rd_en = 1'b0;
  endtask
  task automatic clr_all();
    irq_clr = 7'h7F; step(1); irq_clr = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    step(4); rst = 1'b0; step(1);
    // R11 reset state
    chk("R11 rx_level", rx_level, 0);   chk("R11 tx_level", tx_level, 0);
    chk("R11 rx_empty", rx_empty, 1);   chk("R11 tx_empty", tx_empty, 1);
    chk("R11 full", {tx_full, rx_full}, 0);
    chk("R11 raw", irq_raw, 0);  chk("R11 irq", irq, 0);  chk("R11 busy", busy, 0);

    // R2 pop from empty ignored
    rx_pop(); chk("R2 empty pop level", rx_level, 0); chk("R2 empty pop flag", rx_empty, 1);

    // receive sweep over every threshold code: R1 R2 R3 R4
    for (int sel = 0; sel < 8; sel++) begin
      rx_lvl_sel = 3'(sel); clr_all();
      for (int i = 0; i < 16; i++) begin
        rx_push(8'(i ^ (sel << 4)), 3'b000);
        chk("R1 rx level", rx_level, i + 1);
        chk("R4 rx threshold", irq_raw[0], (i + 1 >= thr(sel)) ? 1 : 0);
      end
      chk("R1 rx full", rx_full, 1);
      chk("R3 no overrun yet", irq_raw[6], 0);
      rx_push(8'hEE, 3'b000);
      chk("R2 rx drop level", rx_level, 16);
      chk("R3 overrun raw", irq_raw[6], 1);
      for (int i = 0; i < 16; i++) begin
        chk("R1 rx order", rx_rd_data[7:0], (i ^ (sel << 4)) & 8'hFF);
        chk("R3 old entry flag", rx_rd_data[11], 0);
        rx_pop();
      end
      chk("R1 rx empty", rx_empty, 1);
      rx_push(8'h5A, 3'b000);
      chk("R3 flag after loss", rx_rd_data[11], 1);
      rx_pop();
      rx_push(8'h5B, 3'b000);
      chk("R3 flag cleared", rx_rd_data[11], 0);
      rx_pop();
    end

    // R2 push and pop together on full receive queue
    rx_lvl_sel = 3'd4; clr_all();
    for (int i = 0; i < 16; i++) rx_push(8'(i), 3'b000);
    rx_wr_en = 1'b1; rx_wr_data = 8'h77; rx_rd_en = 1'b1; step(1);
    rx_wr_en = 1'b0; rx_rd_en = 1'b0;
    chk("R2 full push+pop level", rx_level, 15);
    chk("R2 full push+pop overrun", irq_raw[6], 1);
    for (int i = 1; i < 16; i++) begin
      chk("R2 survivors order", rx_rd_data[7:0], i);
      rx_pop();
    end
    clr_all();

    // transmit sweep: R1 R2 R5 R10
    for (int sel = 0; sel < 8; sel++) begin
      tx_lvl_sel = 3'(sel);
      for (int i = 0; i < 16; i++) tx_push(8'(i + sel * 3));
      chk("R1 tx full", tx_full, 1);
      tx_push(8'hFF);
      chk("R2 tx drop level", tx_level, 16);
      clr_all();
      chk("R10 busy while queued", busy, 1);
      for (int i = 0; i < 16; i++) begin
        chk("R1 tx order", tx_rd_data, (i + sel * 3) & 8'hFF);
        tx_pop();
        chk("R5 tx threshold", irq_raw[1], (15 - i <= thr(sel)) ? 1 : 0);
      end
      chk("R1 tx empty", tx_empty, 1);
      step(1);
      chk("R10 busy idle", busy, 0);
    end
    clr_all();

    // R6 error flags
    for (int st = 0; st < 8; st++) begin
      rx_push(8'(8'hA0 + st), 3'(st));
      chk("R6 framing raw", irq_raw[3], st & 1);
      chk("R6 parity raw", irq_raw[4], (st >> 1) & 1);
      chk("R6 break raw", irq_raw[5], (st >> 2) & 1);
      chk("R6 entry flags", rx_rd_data[10:8], st);
      chk("R6 entry data", rx_rd_data[7:0], 8'hA0 + st);
      rx_pop(); clr_all();
    end

    // R8 set and clear in the same cycle
    rx_lvl_sel = 3'd1;
    for (int i = 0; i < 3; i++) rx_push(8'(i), 3'b000);
    clr_all();
    chk("R8 below threshold", irq_raw[0], 0);
    irq_clr = 7'h01; rx_push(8'h03, 3'b000); irq_clr = '0;
    chk("R8 set beats clear", irq_raw[0], 1);
    step(3);
    chk("R8 sticky", irq_raw[0], 1);
    clr_all();
    chk("R8 clear alone", irq_raw[0], 0);
    for (int i = 0; i < 4; i++) rx_pop();

    // R9 mask sweep
    rx_lvl_sel = 3'd4;
    rx_push(8'h11, 3'b101);
    for (int m = 0; m < 128; m++) begin
      irq_mask = 7'(m); step(1);
      chk("R9 masked", irq_masked, m & 7'h28);
      chk("R9 request", irq, ((m & 7'h28) != 0) ? 1 : 0);
    end
    irq_mask = '0; rx_pop(); clr_all();

    // R7 receive timeout
    baud16_tick = 1'b1;
    rx_push(8'h21, 3'b000);
    step(511); chk("R7 before limit", irq_raw[2], 0);
    step(1);   chk("R7 at limit", irq_raw[2], 1);
    clr_all(); step(600); chk("R7 single event", irq_raw[2], 0);
    rx_push(8'h22, 3'b000); step(300);
    rx_pop();
    step(511); chk("R7 restart by pop", irq_raw[2], 0);
    step(1);   chk("R7 after restart", irq_raw[2], 1);
    for (int i = 0; i < 15; i++) rx_push(8'(i), 3'b000);
    clr_all(); step(600);
    chk("R7 full queue no timeout", irq_raw[2], 0);
    for (int i = 0; i < 16; i++) rx_pop();
    clr_all(); step(600);
    chk("R7 empty queue no timeout", irq_raw[2], 0);
    baud16_tick = 1'b0;

    // R10 busy across shifter activity
    chk("R10 idle", busy, 0);
    tx_push(8'h55);
    chk("R10 rise on write", busy, 1);
    step(3); chk("R10 hold queued", busy, 1);
    tx_shift_active = 1'b1; tx_pop();
    step(5); chk("R10 hold while shifting", busy, 1);
    tx_shift_active = 1'b0; step(1);
    chk("R10 fall when drained", busy, 0);

    finish_run();
  end
endmodule